// File: doc/BRIEF.md
# Dual-Channel Coherent Downconverter with Integrate-and-Dump Decimation

This core takes two real sampled intermediate-frequency streams and brings both to baseband with one shared local oscillator, so the two channels stay phase-coherent. A single phase accumulator advances by a programmed frequency word on every input clock. Two pipelined CORDIC rotators read the same phase value in the same cycle. Each rotator turns its real sample (quadrature input tied to zero) into an I/Q pair.

Each of the four results (I and Q of both channels) is summed over exactly D input samples. The sum is then scaled by a programmable right shift, saturated to the output width, and the integrator is cleared. The four decimated words go out on one strobe-qualified output port in the fixed order I1, Q1, I2, Q2, on four consecutive clocks. A host separates the streams by position. A small register write port sets the frequency word, the decimation count, the output shift and the enable.

Top module: `dual_iad_ddc`

## Requirements
- R1: After reset, and while enable (address 3, bit 0) has not been set to 1, `out_valid` stays low and no word is produced.
- R2: Both channels use the same phase in the same cycle. With equal samples on `adc_a` and `adc_b`, the I1 word equals the I2 word and the Q1 word equals the Q2 word exactly, for any frequency word.
- R3: Channel 1 rotates `adc_a` and channel 2 rotates `adc_b`, each with a zero quadrature input. With frequency word 0 and DC inputs x, the I word is about 1.6468·D·x/2^S (the rotator gain) and the Q word is about 0.
- R4: Each word is the sum of exactly D rotator outputs, and consecutive I1 words are exactly D clocks apart. With a DC input and frequency 0, the words for D=16, S=1 equal those for D=8, S=0.
- R5: A decimation write (address 1) below 8 is clamped to 8, and a write above 2^DEC_W (256 by default) is clamped to 256.
- R6: Words leave as I1, Q1, I2, Q2 on four consecutive clocks with `out_valid` high, starting with I1 after every clear.
- R7: On dump, the sum is arithmetically shifted right by S (address 2, low bits) and saturated to the signed 16-bit range [-32768, 32767].
- R8: A write to the frequency word (address 0) or the decimation (address 1), or enabling from the disabled state, clears the phase, the integrators, the sample counter and the word pointer. The first I1 word appears exactly D+18 clocks after the clock edge that takes the write, and it holds a full D-sample sum.
- R9: The phase advances by the frequency word F (address 0) per input sample, starting from 0 after a clear. With DC input x, the first frame is about 1.6468·x·Σcos(2πFk/2^32) for I and 1.6468·x·Σsin(2πFk/2^32) for Q, summed over k = 0..D-1.
- R10: Writing 0 to enable stops output at once: no further word is produced while disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one ADC sample per channel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 frequency, 1 decimation, 2 shift, 3 enable |
| wr_data | input | 32 | Register write value |
| adc_a | input | 16 | Signed sample for channel 1 |
| adc_b | input | 16 | Signed sample for channel 2 |
| out_valid | output | 1 | Strobe qualifying `out_data` |
| out_data | output | 16 | Decimated word, signed, in I1/Q1/I2/Q2 order |

## Verification
The hardest case to reach is a clear that lands in the middle of a partly filled integration window. Stale partial sums or a stale counter would then show only as a slightly too-large first word or a shifted frame time. The bench runs with a long decimation, lets a frame pass, and rewrites the frequency word partway into the next window. It then checks both the exact arrival clock of the next I1 word and that its value matches a fresh full-window sum. Rotator-gain-dependent values are checked within a tolerance. Exactness is shown by comparing frames against one another (D=16 with S=1 against D=8 with S=0, channel 1 against channel 2).

// File: rtl/iad_pkg.sv
package iad_pkg;

  localparam logic [1:0] ADDR_FREQ  = 2'd0;
  localparam logic [1:0] ADDR_DEC   = 2'd1;
  localparam logic [1:0] ADDR_SHIFT = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;

  // arctan(2^-i) scaled so that a full turn is 2^32
  function automatic logic [31:0] atan32(input int i);
    case (i)
      0:  atan32 = 32'd536870912;
      1:  atan32 = 32'd316933406;
      2:  atan32 = 32'd167458907;
      3:  atan32 = 32'd85004756;
      4:  atan32 = 32'd42667331;
      5:  atan32 = 32'd21354465;
      6:  atan32 = 32'd10679838;
      7:  atan32 = 32'd5340245;
      8:  atan32 = 32'd2670163;
      9:  atan32 = 32'd1335087;
      10: atan32 = 32'd667544;
      11: atan32 = 32'd333772;
      12: atan32 = 32'd166886;
      13: atan32 = 32'd83443;
      14: atan32 = 32'd41722;
      15: atan32 = 32'd20861;
      default: atan32 = 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/iad_rotator.sv
module iad_rotator #(
  parameter int SAMP_W  = 16,
  parameter int PHASE_W = 32,
  parameter int STAGES  = 16,
  parameter int RW      = SAMP_W + 2
) (
  input  logic                      clk,
  input  logic signed [SAMP_W-1:0]  x_in,
  input  logic        [PHASE_W-1:0] phase_in,
  output logic signed [RW-1:0]      i_out,
  output logic signed [RW-1:0]      q_out
);

  for (genvar s = 0; s <= STAGES; s++) begin : g_st
    logic signed [RW-1:0]      x;
    logic signed [RW-1:0]      y;
    logic signed [PHASE_W-1:0] z;

    if (s == 0) begin : g_pre
      // fold quadrants 1 and 2 by a half-turn so the residual angle fits the CORDIC range
      always_ff @(posedge clk) begin
        if (phase_in[PHASE_W-1] ^ phase_in[PHASE_W-2]) begin
          x <= -(RW'(x_in));
          z <= $signed({~phase_in[PHASE_W-1], phase_in[PHASE_W-2:0]});
        end else begin
          x <= RW'(x_in);
          z <= $signed(phase_in);
        end
        y <= '0;
      end
    end else begin : g_rot
      localparam logic signed [PHASE_W-1:0] ANG =
        PHASE_W'(iad_pkg::atan32(s - 1) >> (32 - PHASE_W));
      always_ff @(posedge clk) begin
        if (!g_st[s-1].z[PHASE_W-1]) begin
          x <= g_st[s-1].x - (g_st[s-1].y >>> (s - 1));
          y <= g_st[s-1].y + (g_st[s-1].x >>> (s - 1));
          z <= g_st[s-1].z - ANG;
        end else begin
          x <= g_st[s-1].x + (g_st[s-1].y >>> (s - 1));
          y <= g_st[s-1].y - (g_st[s-1].x >>> (s - 1));
          z <= g_st[s-1].z + ANG;
        end
      end
    end
  end

  assign i_out = g_st[STAGES].x;
  assign q_out = g_st[STAGES].y;

endmodule

// File: rtl/iad_ctrl.sv
module iad_ctrl #(
  parameter int PHASE_W = 32,
  parameter int WR_W    = 32,
  parameter int DEC_W   = 8,
  parameter int SHIFT_W = 5,
  parameter int MIN_DEC = 8,
  parameter int LAT     = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [WR_W-1:0]    wr_data,
  output logic [PHASE_W-1:0] phase,
  output logic               clr,
  output logic               smp_valid,
  output logic               dump,
  output logic               load,
  output logic [SHIFT_W-1:0] shift
);
  import iad_pkg::*;

  localparam int CNT_W   = DEC_W + 1;
  localparam int MAX_DEC = 1 << DEC_W;

  logic [PHASE_W-1:0] freq_q;
  logic [CNT_W-1:0]   dec_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               en_q;
  logic [LAT-1:0]     vpipe;
  logic               wr_clear;

  always_comb begin
    wr_clear = wr_en && ((wr_addr == ADDR_FREQ) || (wr_addr == ADDR_DEC) ||
                         ((wr_addr == ADDR_CTRL) && !wr_data[0]));
  end

  assign clr = rst || !en_q || wr_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
      dec_q  <= CNT_W'(MIN_DEC);
      shift  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_FREQ:  freq_q <= wr_data[PHASE_W-1:0];
        ADDR_DEC: begin
          if (wr_data < WR_W'(MIN_DEC))      dec_q <= CNT_W'(MIN_DEC);
          else if (wr_data > WR_W'(MAX_DEC)) dec_q <= CNT_W'(MAX_DEC);
          else                               dec_q <= wr_data[CNT_W-1:0];
        end
        ADDR_SHIFT: shift <= wr_data[SHIFT_W-1:0];
        default:    en_q  <= wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      phase <= '0;
      vpipe <= '0;
    end else begin
      phase <= phase + freq_q;
      vpipe <= {vpipe[LAT-2:0], 1'b1};
    end
  end

  assign smp_valid = vpipe[LAT-1];
  assign dump      = smp_valid && (cnt_q == dec_q - 1'b1);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      load  <= 1'b0;
    end else begin
      load <= dump;
      if (smp_valid) cnt_q <= dump ? '0 : cnt_q + 1'b1;
    end
  end

  // checker state: clocks since the previous dump
  logic [CNT_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (dump) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_dump_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (dump && seen_q) |-> (gap_q >= CNT_W'(MIN_DEC - 1)));

  p_clear_phase_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == '0));

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !smp_valid);

endmodule

// File: rtl/iad_lane.sv
module iad_lane #(
  parameter int RW      = 18,
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 16,
  parameter int SHIFT_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                smp_valid,
  input  logic                dump,
  input  logic [SHIFT_W-1:0]  shift,
  input  logic signed [RW-1:0] sample,
  output logic [OUT_W-1:0]    result
);

  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] total;
  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    total  = acc + ACC_W'(sample);
    scaled = total >>> shift;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (smp_valid) begin
      if (dump) begin
        acc <= '0;
        if (scaled > SAT_HI)      result <= SAT_HI[OUT_W-1:0];
        else if (scaled < SAT_LO) result <= SAT_LO[OUT_W-1:0];
        else                      result <= scaled[OUT_W-1:0];
      end else begin
        acc <= total;
      end
    end
  end

  p_dump_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && dump && !clr) |=> (acc == '0));

endmodule

// File: rtl/iad_serial.sv
module iad_serial #(
  parameter int OUT_W = 16,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       load,
  input  logic [LANES-1:0][OUT_W-1:0] words,
  output logic                       out_valid,
  output logic [OUT_W-1:0]           out_data
);

  localparam int PTR_W = $clog2(LANES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LANES - 1);

  logic [PTR_W-1:0] ptr;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr       <= '0;
      busy      <= 1'b0;
      out_valid <= 1'b0;
    end else if (load) begin
      out_data  <= words[0];
      out_valid <= 1'b1;
      ptr       <= PTR_W'(1);
      busy      <= 1'b1;
    end else if (busy) begin
      out_data  <= words[ptr];
      out_valid <= 1'b1;
      ptr       <= ptr + 1'b1;
      busy      <= (ptr != LAST);
    end else begin
      out_valid <= 1'b0;
    end
  end

  p_load_idle_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

  p_load_emits_r6: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> out_valid);

endmodule

// File: rtl/dual_iad_ddc.sv
module dual_iad_ddc #(
  parameter int SAMP_W  = 16,
  parameter int OUT_W   = 16,
  parameter int PHASE_W = 32,
  parameter int STAGES  = 16,
  parameter int MAX_DEC = 256,
  parameter int WR_W    = 32,
  parameter int MIN_DEC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic [SAMP_W-1:0] adc_a,
  input  logic [SAMP_W-1:0] adc_b,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);

  localparam int DEC_W   = $clog2(MAX_DEC);
  localparam int RW      = SAMP_W + 2;
  localparam int ACC_W   = RW + DEC_W;
  localparam int SHIFT_W = $clog2(ACC_W);
  localparam int CHANS   = 2;
  localparam int LANES   = 2 * CHANS;

  logic [PHASE_W-1:0]          phase;
  logic                        clr;
  logic                        smp_valid;
  logic                        dump;
  logic                        load;
  logic [SHIFT_W-1:0]          shift;
  logic [CHANS-1:0][SAMP_W-1:0] adc_in;
  logic [LANES-1:0][RW-1:0]    rot;
  logic [LANES-1:0][OUT_W-1:0] words;

  assign adc_in = {adc_b, adc_a};

  iad_ctrl #(
    .PHASE_W(PHASE_W), .WR_W(WR_W), .DEC_W(DEC_W), .SHIFT_W(SHIFT_W),
    .MIN_DEC(MIN_DEC), .LAT(STAGES + 1)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase(phase), .clr(clr), .smp_valid(smp_valid), .dump(dump),
    .load(load), .shift(shift)
  );

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    iad_rotator #(
      .SAMP_W(SAMP_W), .PHASE_W(PHASE_W), .STAGES(STAGES), .RW(RW)
    ) u_rot (
      .clk(clk), .x_in(adc_in[c]), .phase_in(phase),
      .i_out(rot[2*c]), .q_out(rot[2*c+1])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    iad_lane #(
      .RW(RW), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
    ) u_lane (
      .clk(clk), .rst(rst), .clr(clr), .smp_valid(smp_valid), .dump(dump),
      .shift(shift), .sample(rot[l]), .result(words[l])
    );
  end

  iad_serial #(.OUT_W(OUT_W), .LANES(LANES)) u_ser (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .words(words),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: tb/test_dual_iad_ddc.sv
`timescale 1ns/1ps
module test_dual_iad_ddc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] adc_a = '0;
  logic [15:0] adc_b = '0;
  logic        out_valid;
  logic [15:0] out_data;

  dual_iad_ddc i_dual_iad_ddc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .adc_a(adc_a), .adc_b(adc_b), .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int wcyc    = 0;

  int    gv[$];
  int    gc[$];
  int    ev[$];
  int    etol[$];
  string et[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp, input int tol);
    n_tests++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  // monitor: log every word and compare against the scoreboard queue
  always @(negedge clk) begin
    if (out_valid === 1'b1) begin
      int v;
      v = int'($signed(out_data));
      gv.push_back(v);
      gc.push_back(cyc);
      if (ev.size() > 0) check(et.pop_front(), v, ev.pop_front(), etol.pop_front());
    end
  end

  task automatic expect_word(input int v, input int tol, input string tag);
    ev.push_back(v);
    etol.push_back(tol);
    et.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wcyc = cyc;
  endtask

  task automatic configure(input int sh, input int dec, input logic [31:0] fw);
    wr(2'd3, 32'd0);
    wr(2'd2, 32'(sh));
    wr(2'd1, 32'(dec));
    wr(2'd0, fw);
    wr(2'd3, 32'd1);
    gv.delete(); gc.delete();
  endtask

  task automatic get_frame(output int w[4], output int c);
    while (gv.size() < 4) @(negedge clk);
    c = gc[0];
    for (int k = 0; k < 4; k++) begin
      int ck;
      w[k] = gv.pop_front();
      ck = gc.pop_front();
      if (k > 0) check("R6 consecutive slot", ck, c + k, 0);
    end
  endtask

  function automatic int model(input int dec, input int x, input int sh,
                               input longint fw, input bit quad);
    real s;
    real r;
    s = 0.0;
    for (int k = 0; k < dec; k++) begin
      real a;
      a = 6.283185307179586 * real'((fw * k) % 64'sh1_0000_0000) / 4294967296.0;
      s += quad ? $sin(a) : $cos(a);
    end
    r = real'(x) * 1.6467602 * s / real'(1 << sh);
    if (r > 32767.0) r = 32767.0;
    if (r < -32768.0) r = -32768.0;
    return $rtoi(r);
  endfunction

  task automatic drained(input string req);
    check(req, ev.size(), 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int f8[4];
    int w[4];
    int c1;
    int c2;

    repeat (4) @(negedge clk);
    check("R1 out_valid during reset", int'(out_valid), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0, 0);

    // R1: registers written but enable never set
    adc_a = 16'sd1000; adc_b = -16'sd2000;
    wr(2'd1, 32'd8);
    wr(2'd0, 32'd0);
    repeat (60) @(negedge clk);
    check("R1 no words while never enabled", gv.size(), 0, 0);

    // R3/R6/R8/R4: DC input, zero frequency, D=8
    configure(0, 8, 32'd0);
    expect_word(model(8, 1000, 0, 0, 0), 192, "R3 I1 slot");
    expect_word(0, 192, "R3 Q1 slot");
    expect_word(model(8, -2000, 0, 0, 0), 192, "R3 I2 slot");
    expect_word(0, 192, "R3 Q2 slot");
    get_frame(f8, c1);
    check("R8 first I1 at D+18", c1, wcyc + 26, 0);
    get_frame(w, c2);
    check("R4 frame period D=8", c2 - c1, 8, 0);
    drained("R6 all four words seen");

    // R4: exact integration count
    configure(1, 16, 32'd0);
    for (int k = 0; k < 4; k++) expect_word(f8[k], 0, "R4 D16 S1 equals D8 S0");
    get_frame(w, c1);
    get_frame(w, c2);
    check("R4 frame period D=16", c2 - c1, 16, 0);
    drained("R4 scoreboard");

    // R5: clamping both ways
    configure(0, 3, 32'd0);
    get_frame(w, c1);
    check("R5 low clamp first frame", c1, wcyc + 26, 0);
    get_frame(w, c2);
    check("R5 low clamp period", c2 - c1, 8, 0);
    check("R5 low clamp I1 value", w[0], f8[0], 0);
    configure(0, 1000, 32'd0);
    get_frame(w, c1);
    check("R5 high clamp first frame", c1, wcyc + 274, 0);
    get_frame(w, c2);
    check("R5 high clamp period", c2 - c1, 256, 0);

    // R7: saturation and shift
    adc_a = 16'sd20000; adc_b = -16'sd20000;
    configure(0, 8, 32'd0);
    expect_word(32767, 0, "R7 I1 saturates high");
    expect_word(0, 192, "R7 Q1 near zero");
    expect_word(-32768, 0, "R7 I2 saturates low");
    expect_word(0, 192, "R7 Q2 near zero");
    get_frame(w, c1);
    drained("R7 scoreboard");
    adc_a = 16'sd1000; adc_b = -16'sd2000;
    configure(3, 8, 32'd0);
    for (int k = 0; k < 4; k++) expect_word(f8[k] >>> 3, 0, "R7 shift by 3");
    get_frame(w, c1);
    drained("R7 shift scoreboard");

    // R9/R2: nonzero frequency, equal inputs on both channels
    adc_a = 16'sd1500; adc_b = 16'sd1500;
    configure(0, 8, 32'h1000_0000);
    expect_word(model(8, 1500, 0, 64'h1000_0000, 0), 192, "R9 I1 tone 1/16");
    expect_word(model(8, 1500, 0, 64'h1000_0000, 1), 192, "R9 Q1 tone 1/16");
    get_frame(w, c1);
    check("R2 I1 equals I2", w[0], w[2], 0);
    check("R2 Q1 equals Q2", w[1], w[3], 0);
    configure(0, 8, 32'h2000_0000);
    expect_word(0, 192, "R9 I1 full turn");
    expect_word(0, 192, "R9 Q1 full turn");
    get_frame(w, c1);
    check("R2 I equal at 1/8", w[0], w[2], 0);
    check("R2 Q equal at 1/8", w[1], w[3], 0);
    drained("R9 scoreboard");

    // R8: clear in the middle of a window
    adc_a = 16'sd1000; adc_b = -16'sd2000;
    configure(3, 40, 32'd0);
    get_frame(w, c1);
    repeat (25) @(negedge clk);
    wr(2'd0, 32'd0);
    gv.delete(); gc.delete();
    expect_word(model(40, 1000, 3, 0, 0), 120, "R8 full sum after mid-window clear");
    get_frame(w, c2);
    check("R8 I1 at D+18 after mid-window clear", c2, wcyc + 58, 0);
    drained("R8 scoreboard");

    // R10: disable stops output
    wr(2'd3, 32'd0);
    gv.delete(); gc.delete();
    repeat (100) @(negedge clk);
    check("R10 no words after disable", gv.size(), 0, 0);
    check("R10 out_valid low", int'(out_valid), 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule